// File: doc/BRIEF.md
# Debug and Boot Lock Controller

This block holds the security control state of an embedded flash controller. It combines the readout protection level with a software debug-enable bit to decide whether external debug access is allowed. At the highest level, hardware forces debug off. It also keeps a sticky boot-lock bit. While that bit is set, the boot selection is forced to main flash and the external boot-mode inputs are ignored.

Setting the boot lock is always accepted. Clearing it is allowed freely at level 0. At level 1 a clear is allowed only after a full mass erase has completed while a regression to level 0 is requested. A small qualification flag records that condition. Any clear that does not qualify is dropped, and a one-cycle reject flag reports it.

A securable-region protect bit marks the securable memory as secured. Once set, only a reset clears it. On reset, the boot lock and the protect bit load from option-byte inputs, and the debug-enable bit starts at 1. Option-byte storage, the flash array and the erase sequencing are outside the block.

Top module: `dbg_boot_lock_ctrl`

## Requirements
- R1: While rst_n is low at a rising edge, boot_lock loads opt_boot_lock, secured loads opt_sec_prot, the software debug bit loads 1 and clr_reject loads 0.
- R2: When prot_level is 2 or 3, debug_enable is 0 whatever the software debug bit holds. Code 3 counts as the highest level.
- R3: When prot_level is 0 or 1, debug_enable equals the software debug bit. A dbg_wr with dbg_wdata takes effect after the next rising edge.
- R4: boot_sel equals BOOT_MAIN (default 0) while boot_lock is 1. Otherwise it equals boot_mode_in.
- R5: A lock_wr with lock_wdata=1 sets boot_lock at the next edge at every protection level.
- R6: A lock_wr with lock_wdata=0 at prot_level 0 clears boot_lock at the next edge.
- R7: At prot_level 1, a clear write is accepted only if the erase qualification flag is already set. The flag is set by an edge that has erase_done=1 while regress_req=1.
- R8: A clear write that is not accepted leaves boot_lock unchanged, and clr_reject is 1 for the cycle after that edge only. Level 2 or 3 always rejects.
- R9: The erase qualification flag is cleared at an edge with an accepted clear write, or at any edge with regress_req=0. A later clear at level 1 is then rejected until a new erase completes.
- R10: A sec_wr with sec_wdata=1 sets secured. A sec_wr with sec_wdata=0 has no effect, and only reset clears secured.
- R11: When erase_done and a level-1 clear write fall in the same cycle, the clear is judged on the flag value from before that edge. With the flag clear, the write is rejected and the flag is set for the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| prot_level | input | LVL_W | Readout protection level (0, 1, 2; 3 treated as 2) |
| opt_boot_lock | input | 1 | Option-byte value loaded into boot_lock on reset |
| opt_sec_prot | input | 1 | Option-byte value loaded into secured on reset |
| dbg_wr | input | 1 | Write strobe for the software debug bit |
| dbg_wdata | input | 1 | Data for the software debug bit |
| lock_wr | input | 1 | Write strobe for boot_lock |
| lock_wdata | input | 1 | 1 sets, 0 requests a clear |
| sec_wr | input | 1 | Write strobe for the protect bit |
| sec_wdata | input | 1 | 1 sets the protect bit |
| regress_req | input | 1 | Level-0 regression requested |
| erase_done | input | 1 | Mass-erase-complete pulse |
| boot_mode_in | input | BOOT_W | Boot mode from the other boot options |
| debug_enable | output | 1 | External debug access allowed |
| boot_lock | output | 1 | Sticky boot lock |
| boot_sel | output | BOOT_W | Effective boot selection |
| secured | output | 1 | Securable memory is secured |
| clr_reject | output | 1 | One-cycle pulse for a dropped clear write |

## Verification
The erase-complete pulse and a level-1 clear write can fall in the same cycle. Whether that clear is honoured depends on the ordering between the qualification flag and the lock register. The bench provokes this directly by driving erase_done and a clear write in one cycle. It expects a reject pulse, then an accepted clear on the following write. Random cycles also let the two coincide, together with regression withdrawals, and every cycle is judged against a bench model that applies the old-flag rule.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
   typedef struct packed {
      logic wr;
      logic data;
   } wcmd_t;

   typedef enum logic [1:0] {
      LV_OPEN = 2'd0,
      LV_GUARD = 2'd1,
      LV_SEALED = 2'd2
   } lvl_class_t;

   function automatic lvl_class_t classify(input logic [7:0] lvl);
      if (lvl == 8'd0) return LV_OPEN;
      else if (lvl == 8'd1) return LV_GUARD;
      else return LV_SEALED;
   endfunction
endpackage

// File: rtl/dbl_debug_gate.sv
module dbl_debug_gate #(
   parameter int LVL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] prot_level,
   input  dbl_pkg::wcmd_t   cmd,
   output logic             debug_enable
);
   import dbl_pkg::*;
   logic sw_en_q;
   lvl_class_t cls;

   always_comb cls = classify(8'(prot_level));

   always_ff @(posedge clk) begin
      if (!rst_n) sw_en_q <= 1'b1;
      else if (cmd.wr) sw_en_q <= cmd.data;
   end

   always_comb debug_enable = sw_en_q && (cls != LV_SEALED);
endmodule

// File: rtl/dbl_boot_lock.sv
module dbl_boot_lock #(
   parameter int LVL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             opt_lock,
   input  logic [LVL_W-1:0] prot_level,
   input  dbl_pkg::wcmd_t   cmd,
   input  logic             regress_req,
   input  logic             erase_done,
   output logic             boot_lock,
   output logic             clr_reject
);
   import dbl_pkg::*;
   logic lock_q, qual_q, rej_q;
   logic clr_try, clr_ok;
   lvl_class_t cls;

   always_comb begin
      cls     = classify(8'(prot_level));
      clr_try = cmd.wr && !cmd.data;
      clr_ok  = clr_try && ((cls == LV_OPEN) || ((cls == LV_GUARD) && qual_q));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= opt_lock;
         qual_q <= 1'b0;
         rej_q  <= 1'b0;
      end else begin
         rej_q <= clr_try && !clr_ok;
         if (cmd.wr && cmd.data) lock_q <= 1'b1;
         else if (clr_ok)        lock_q <= 1'b0;
         if (clr_ok || !regress_req) qual_q <= 1'b0;
         else if (erase_done)        qual_q <= 1'b1;
      end
   end

   assign boot_lock  = lock_q;
   assign clr_reject = rej_q;
endmodule

// File: rtl/dbl_sec_latch.sv
module dbl_sec_latch (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           opt_sec,
   input  dbl_pkg::wcmd_t cmd,
   output logic           secured
);
   logic sec_q;
   always_ff @(posedge clk) begin
      if (!rst_n) sec_q <= opt_sec;
      else if (cmd.wr && cmd.data) sec_q <= 1'b1;
   end
   assign secured = sec_q;
endmodule

// File: rtl/dbg_boot_lock_ctrl.sv
module dbg_boot_lock_ctrl #(
   parameter int LVL_W = 2,
   parameter int BOOT_W = 2,
   parameter logic [BOOT_W-1:0] BOOT_MAIN = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  prot_level,
   input  logic              opt_boot_lock,
   input  logic              opt_sec_prot,
   input  logic              dbg_wr,
   input  logic              dbg_wdata,
   input  logic              lock_wr,
   input  logic              lock_wdata,
   input  logic              sec_wr,
   input  logic              sec_wdata,
   input  logic              regress_req,
   input  logic              erase_done,
   input  logic [BOOT_W-1:0] boot_mode_in,
   output logic              debug_enable,
   output logic              boot_lock,
   output logic [BOOT_W-1:0] boot_sel,
   output logic              secured,
   output logic              clr_reject
);
   import dbl_pkg::*;

   generate
      if (LVL_W < 2 || LVL_W > 8) begin : g_bad_lvl
         $error("LVL_W must be 2..8");
      end
      if (BOOT_W < 1) begin : g_bad_boot
         $error("BOOT_W must be at least 1");
      end
   endgenerate

   wcmd_t dbg_cmd, lock_cmd, sec_cmd;
   always_comb begin
      dbg_cmd  = '{wr: dbg_wr,  data: dbg_wdata};
      lock_cmd = '{wr: lock_wr, data: lock_wdata};
      sec_cmd  = '{wr: sec_wr,  data: sec_wdata};
   end

   dbl_debug_gate #(.LVL_W(LVL_W)) u_dbg (
      .clk(clk), .rst_n(rst_n), .prot_level(prot_level),
      .cmd(dbg_cmd), .debug_enable(debug_enable));

   dbl_boot_lock #(.LVL_W(LVL_W)) u_lock (
      .clk(clk), .rst_n(rst_n), .opt_lock(opt_boot_lock),
      .prot_level(prot_level), .cmd(lock_cmd),
      .regress_req(regress_req), .erase_done(erase_done),
      .boot_lock(boot_lock), .clr_reject(clr_reject));

   dbl_sec_latch u_sec (
      .clk(clk), .rst_n(rst_n), .opt_sec(opt_sec_prot),
      .cmd(sec_cmd), .secured(secured));

   always_comb boot_sel = boot_lock ? BOOT_MAIN : boot_mode_in;
endmodule

// File: rtl/dbl_checker.sv
module dbl_checker #(
   parameter int LVL_W = 2,
   parameter int BOOT_W = 2,
   parameter logic [BOOT_W-1:0] BOOT_MAIN = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [LVL_W-1:0]  prot_level,
   input logic              lock_wr,
   input logic              lock_wdata,
   input logic              debug_enable,
   input logic              boot_lock,
   input logic [BOOT_W-1:0] boot_sel,
   input logic              secured,
   input logic              clr_reject
);
   a_r2_hw_debug_off: assert property (@(posedge clk) disable iff (!rst_n)
      (prot_level >= LVL_W'(2)) |-> !debug_enable);
   a_r4_boot_forced: assert property (@(posedge clk) disable iff (!rst_n)
      boot_lock |-> (boot_sel == BOOT_MAIN));
   a_r5_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && lock_wdata) |=> boot_lock);
   a_r6_open_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && !lock_wdata && prot_level == '0) |=> (!boot_lock && !clr_reject));
   a_r8_sealed_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (lock_wr && !lock_wdata && prot_level >= LVL_W'(2)) |=> (clr_reject && $stable(boot_lock)));
   a_r8_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
      clr_reject |-> $past(lock_wr && !lock_wdata));
   a_r10_secured_holds: assert property (@(posedge clk) disable iff (!rst_n)
      secured |=> secured);
endmodule

bind dbg_boot_lock_ctrl dbl_checker #(.LVL_W(LVL_W), .BOOT_W(BOOT_W), .BOOT_MAIN(BOOT_MAIN)) i_dbl_checker (
   .clk(clk), .rst_n(rst_n), .prot_level(prot_level), .lock_wr(lock_wr),
   .lock_wdata(lock_wdata), .debug_enable(debug_enable), .boot_lock(boot_lock),
   .boot_sel(boot_sel), .secured(secured), .clr_reject(clr_reject));

// File: tb/test_dbg_boot_lock_ctrl.sv
module test_dbg_boot_lock_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] prot_level = '0;
   logic opt_boot_lock = 1'b0, opt_sec_prot = 1'b0;
   logic dbg_wr = 1'b0, dbg_wdata = 1'b0, lock_wr = 1'b0, lock_wdata = 1'b0;
   logic sec_wr = 1'b0, sec_wdata = 1'b0, regress_req = 1'b0, erase_done = 1'b0;
   logic [1:0] boot_mode_in = '0;
   logic debug_enable, boot_lock, secured, clr_reject;
   logic [1:0] boot_sel;

   int checks = 0, failures = 0;
   bit m_dbg, m_lock, m_sec, m_qual, m_rej;
   bit done = 0;

   always #4 clk = ~clk;

   dbg_boot_lock_ctrl i_dbg_boot_lock_ctrl (
      .clk(clk), .rst_n(rst_n), .prot_level(prot_level),
      .opt_boot_lock(opt_boot_lock), .opt_sec_prot(opt_sec_prot),
      .dbg_wr(dbg_wr), .dbg_wdata(dbg_wdata), .lock_wr(lock_wr), .lock_wdata(lock_wdata),
      .sec_wr(sec_wr), .sec_wdata(sec_wdata), .regress_req(regress_req),
      .erase_done(erase_done), .boot_mode_in(boot_mode_in),
      .debug_enable(debug_enable), .boot_lock(boot_lock), .boot_sel(boot_sel),
      .secured(secured), .clr_reject(clr_reject));

   task automatic check(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic bit exp_debug(logic [1:0] lv, bit sw);
      return (lv < 2) ? sw : 1'b0;
   endfunction

   function automatic bit clear_ok(logic [1:0] lv, bit qual);
      return (lv == 0) || (lv == 1 && qual);
   endfunction

   task automatic do_reset(bit ol, bit os);
      rst_n = 1'b0; opt_boot_lock = ol; opt_sec_prot = os;
      dbg_wr = 0; lock_wr = 0; sec_wr = 0; erase_done = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_dbg = 1; m_lock = ol; m_sec = os; m_qual = 0; m_rej = 0;
      prot_level = 0;
      #1;
      check("R1", "boot_lock", boot_lock, ol);
      check("R1", "secured", secured, os);
      check("R1", "clr_reject", clr_reject, 0);
      check("R1", "debug_enable", debug_enable, 1);
   endtask

   task automatic step(string tag, logic [1:0] lv, bit dw, bit dd, bit lw, bit ld,
                       bit sw, bit sd, bit rq, bit ed, logic [1:0] bm);
      bit acc;
      prot_level = lv; dbg_wr = dw; dbg_wdata = dd; lock_wr = lw; lock_wdata = ld;
      sec_wr = sw; sec_wdata = sd; regress_req = rq; erase_done = ed; boot_mode_in = bm;
      #1;
      check(lv < 2 ? "R3" : "R2", "debug_enable", debug_enable, exp_debug(lv, m_dbg));
      check("R4", "boot_sel", boot_sel, m_lock ? 0 : bm);
      acc = lw && !ld && clear_ok(lv, m_qual);
      m_rej = lw && !ld && !acc;
      if (lw && ld) m_lock = 1; else if (acc) m_lock = 0;
      if (acc || !rq) m_qual = 0; else if (ed) m_qual = 1;
      if (dw) m_dbg = dd;
      if (sw && sd) m_sec = 1;
      @(negedge clk);
      dbg_wr = 0; lock_wr = 0; sec_wr = 0; erase_done = 0;
      check(tag, "boot_lock", boot_lock, m_lock);
      check(tag, "clr_reject", clr_reject, m_rej);
      check("R10", "secured", secured, m_sec);
   endtask

   initial begin
      do_reset(1, 0);
      // R3: debug write at level 0, then level 1
      step("R3", 0, 1, 0, 0, 0, 0, 0, 0, 0, 2'd3);
      step("R3", 1, 1, 1, 0, 0, 0, 0, 0, 0, 2'd3);
      // R2: level 2 and 3 force off even with sw bit 1
      step("R2", 2, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1);
      step("R2", 3, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1);
      // R8: clear at level 2 rejected, single pulse
      step("R8", 2, 0, 0, 1, 0, 0, 0, 1, 0, 2'd2);
      step("R8", 2, 0, 0, 0, 0, 0, 0, 1, 0, 2'd2);
      // R7: level 1 clear without erase rejected
      step("R7", 1, 0, 0, 1, 0, 0, 0, 1, 0, 2'd2);
      // R11: erase and clear together -> rejected, next clear accepted
      step("R11", 1, 0, 0, 1, 0, 0, 0, 1, 1, 2'd2);
      step("R11", 1, 0, 0, 1, 0, 0, 0, 1, 0, 2'd2);
      check("R11", "boot_lock after clear", boot_lock, 0);
      // R4: unlocked passes boot mode
      step("R4", 1, 0, 0, 0, 0, 0, 0, 1, 0, 2'd2);
      // R5: set at level 2
      step("R5", 2, 0, 0, 1, 1, 0, 0, 1, 0, 2'd1);
      // R9: flag consumed, clear rejected
      step("R9", 1, 0, 0, 1, 0, 0, 0, 1, 0, 2'd1);
      check("R9", "boot_lock kept", boot_lock, 1);
      // R9: erase then withdraw regression -> rejected
      step("R9", 1, 0, 0, 0, 0, 0, 0, 1, 1, 2'd1);
      step("R9", 1, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1);
      step("R9", 1, 0, 0, 1, 0, 0, 0, 1, 0, 2'd1);
      // R7: erase in earlier cycle, then clear accepted
      step("R7", 1, 0, 0, 0, 0, 0, 0, 1, 1, 2'd1);
      step("R7", 1, 0, 0, 1, 0, 0, 0, 1, 0, 2'd1);
      check("R7", "boot_lock cleared", boot_lock, 0);
      // R6: level 0 clear
      step("R5", 0, 0, 0, 1, 1, 0, 0, 0, 0, 2'd3);
      step("R6", 0, 0, 0, 1, 0, 0, 0, 0, 0, 2'd3);
      // R10: zero write ignored, set sticks
      step("R10", 0, 0, 0, 0, 0, 1, 0, 0, 0, 2'd3);
      step("R10", 0, 0, 0, 0, 0, 1, 1, 0, 0, 2'd3);
      step("R10", 0, 0, 0, 0, 0, 1, 0, 0, 0, 2'd3);
      check("R10", "secured sticky", secured, 1);
      do_reset(0, 0);
      check("R10", "secured cleared by reset", secured, 0);
      begin
         int unsigned seed;
         seed = 32'h5eed_1234;
         void'($urandom(seed));
         for (int i = 0; i < 3000; i++) begin
            logic [1:0] lv;
            lv = 2'($urandom_range(3));
            step("R8", lv, $urandom_range(3) == 0, $urandom_range(1), $urandom_range(2) == 0,
                 $urandom_range(2) == 0, $urandom_range(15) == 0, $urandom_range(1),
                 $urandom_range(5) != 0, $urandom_range(3) == 0, 2'($urandom_range(3)));
            if (i % 997 == 500) do_reset($urandom_range(1), $urandom_range(1));
         end
      end
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule